// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the effective address that a small 8-bit processor core uses to reach its operand. From the decoded addressing mode, the one or two operand bytes fetched after the opcode, the 16-bit index register and the program counter value after fetch, it works out one of several things. For memory modes it gives the operand address and that address plus one. For a branch it gives the target and decides whether the branch is taken. For register-only or in-instruction data it signals that no memory cycle is wanted.

The address-forming logic is combinational. All results are captured together into one output register when the sequencer pulses the load strobe, and they stay there until the next strobe. The address-plus-one output lets the sequencer fetch the low byte of big-endian 16-bit data (high byte at the lower address) without an extra add. Branch evaluation covers only the branch-if-not-equal condition, which tests the zero flag.

Top module: `eag_core`

## Requirements
- R1: With mode code 3 (full address), the registered address is {op_hi, op_lo}, with op_hi as the upper byte, and mem_req is 1.
- R2: With mode code 2 (page zero), the registered address is {8'h00, op_lo} whatever op_hi holds, and mem_req is 1.
- R3: With mode code 4 (indexed), the registered address is index_x plus op_lo zero-extended, modulo 2^16, and mem_req is 1.
- R4: With mode code 5 (relative), br_target is pc_next plus op_lo sign-extended, modulo 2^16. pc_next is the address that follows the whole branch instruction.
- R5: br_taken is 1 only when the mode code is 5 and zero_flag is 0. In every mode other than 5, br_taken and br_target are 0.
- R6: Mode codes 0 (register only), 1 (data in instruction), 5 (relative) and the unused codes 6 and 7 give mem_req 0, with ea and ea_plus1 both 0.
- R7: When mem_req is 1, ea_plus1 equals ea + 1 modulo 2^16, so address FFFF is followed by 0000.
- R8: Outputs change only on a rising clock edge where load is 1. Input changes while load is 0 leave every output as it was.
- R9: A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures the computed results on this edge |
| mode | input | 3 | Addressing mode code (0..7) |
| op_hi | input | 8 | First operand byte (upper address byte in full-address mode) |
| op_lo | input | 8 | Second or only operand byte (low byte, offset, or branch displacement) |
| index_x | input | 16 | Index register value, only read |
| pc_next | input | 16 | Program counter after the whole instruction has been fetched |
| zero_flag | input | 1 | Zero condition bit |
| ea | output | 16 | Registered effective address |
| ea_plus1 | output | 16 | Registered effective address plus one |
| mem_req | output | 1 | Registered flag: a memory operand access is needed |
| br_target | output | 16 | Registered branch target |
| br_taken | output | 1 | Registered branch-taken decision |

## Verification
The assertions assume that mode, operand bytes, index_x, pc_next and zero_flag are steady at the edge where load is 1. They also assume reset is held for at least one edge before checking begins. The bench drives every input on the falling edge and keeps it until after the next rising edge, so each capture sees settled values. Codes 6 and 7 are applied on purpose, because the assertions about modes without a memory access count those codes among them.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_INHERENT  = 3'd0,
        AM_IMMEDIATE = 3'd1,
        AM_PAGE0     = 3'd2,
        AM_FULL      = 3'd3,
        AM_INDEXED   = 3'd4,
        AM_RELATIVE  = 3'd5
    } amode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] ea_plus1;
        logic              mem_req;
        logic [ADDR_W-1:0] br_target;
        logic              br_taken;
    } ea_result_t;

    function automatic logic [ADDR_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                     input logic [BYTE_W-1:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic [ADDR_W-1:0] page0_addr(input logic [BYTE_W-1:0] lo);
        return {{(ADDR_W-BYTE_W){1'b0}}, lo};
    endfunction

    function automatic logic is_relative(input logic [MODE_W-1:0] code);
        return code == AM_RELATIVE;
    endfunction

endpackage

// File: rtl/eag_offset_add.sv
module eag_offset_add #(
    parameter int AW     = 16,
    parameter int OW     = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] offset,
    output logic [AW-1:0] sum
);
    localparam int EXT_W = AW - OW;

    logic [AW-1:0] off_ext;

    generate
        if (SIGNED) begin : g_sext
            assign off_ext = {{EXT_W{offset[OW-1]}}, offset};
        end else begin : g_zext
            assign off_ext = {{EXT_W{1'b0}}, offset};
        end
    endgenerate

    assign sum = base + off_ext;
endmodule

// File: rtl/eag_operand_sel.sv
module eag_operand_sel
    import eag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [BW-1:0]     op_hi,
    input  logic [BW-1:0]     op_lo,
    input  logic [AW-1:0]     index_x,
    output logic [AW-1:0]     base,
    output logic [BW-1:0]     offset,
    output logic              mem_req
);
    amode_e m;
    assign m = amode_e'(mode);

    always_comb begin
        base    = '0;
        offset  = '0;
        mem_req = 1'b0;
        case (m)
            AM_FULL: begin
                base    = join_bytes(op_hi, op_lo);
                mem_req = 1'b1;
            end
            AM_PAGE0: begin
                base    = page0_addr(op_lo);
                mem_req = 1'b1;
            end
            AM_INDEXED: begin
                base    = index_x;
                offset  = op_lo;
                mem_req = 1'b1;
            end
            default: begin
                base    = '0;
                offset  = '0;
                mem_req = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/eag_branch_eval.sv
module eag_branch_eval
    import eag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [BW-1:0]     disp,
    input  logic [AW-1:0]     pc_next,
    input  logic              zero_flag,
    output logic [AW-1:0]     target,
    output logic              taken
);
    logic [AW-1:0] raw_target;
    logic          rel;

    eag_offset_add #(.AW(AW), .OW(BW), .SIGNED(1'b1)) u_pcrel (
        .base   (pc_next),
        .offset (disp),
        .sum    (raw_target)
    );

    assign rel    = is_relative(mode);
    assign target = rel ? raw_target : '0;
    assign taken  = rel & ~zero_flag;
endmodule

// File: rtl/eag_core.sv
module eag_core
    import eag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] mode,
    input  logic [BW-1:0]     op_hi,
    input  logic [BW-1:0]     op_lo,
    input  logic [AW-1:0]     index_x,
    input  logic [AW-1:0]     pc_next,
    input  logic              zero_flag,
    output logic [AW-1:0]     ea,
    output logic [AW-1:0]     ea_plus1,
    output logic              mem_req,
    output logic [AW-1:0]     br_target,
    output logic              br_taken
);
    logic [AW-1:0] base_w;
    logic [BW-1:0] off_w;
    logic          mem_w;
    logic [AW-1:0] ea_w;
    logic [AW-1:0] ea_inc_w;
    logic [AW-1:0] tgt_w;
    logic          tk_w;
    ea_result_t    nxt;
    ea_result_t    res_q;

    eag_operand_sel #(.AW(AW), .BW(BW)) u_sel (
        .mode    (mode),
        .op_hi   (op_hi),
        .op_lo   (op_lo),
        .index_x (index_x),
        .base    (base_w),
        .offset  (off_w),
        .mem_req (mem_w)
    );

    eag_offset_add #(.AW(AW), .OW(BW), .SIGNED(1'b0)) u_ea_add (
        .base   (base_w),
        .offset (off_w),
        .sum    (ea_w)
    );

    eag_offset_add #(.AW(AW), .OW(1), .SIGNED(1'b0)) u_next_byte (
        .base   (ea_w),
        .offset (1'b1),
        .sum    (ea_inc_w)
    );

    eag_branch_eval #(.AW(AW), .BW(BW)) u_br (
        .mode      (mode),
        .disp      (op_lo),
        .pc_next   (pc_next),
        .zero_flag (zero_flag),
        .target    (tgt_w),
        .taken     (tk_w)
    );

    always_comb begin
        nxt.ea        = ea_w;
        nxt.ea_plus1  = mem_w ? ea_inc_w : '0;
        nxt.mem_req   = mem_w;
        nxt.br_target = tgt_w;
        nxt.br_taken  = tk_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (load) begin
            res_q <= nxt;
        end
    end

    assign ea        = res_q.ea;
    assign ea_plus1  = res_q.ea_plus1;
    assign mem_req   = res_q.mem_req;
    assign br_target = res_q.br_target;
    assign br_taken  = res_q.br_taken;
endmodule

// File: rtl/eag_checker.sv
module eag_checker
    import eag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [MODE_W-1:0] mode,
    input logic [BYTE_W-1:0] op_hi,
    input logic [BYTE_W-1:0] op_lo,
    input logic              zero_flag,
    input logic [ADDR_W-1:0] ea,
    input logic [ADDR_W-1:0] ea_plus1,
    input logic              mem_req,
    input logic [ADDR_W-1:0] br_target,
    input logic              br_taken
);
    a_r1_full_addr: assert property (@(posedge clk) disable iff (rst)
        (load && mode == AM_FULL) |=> (ea == {$past(op_hi), $past(op_lo)}) && mem_req);

    a_r2_page0: assert property (@(posedge clk) disable iff (rst)
        (load && mode == AM_PAGE0) |=> (ea[ADDR_W-1:BYTE_W] == '0) && mem_req);

    a_r5_not_taken_on_zero: assert property (@(posedge clk) disable iff (rst)
        (load && zero_flag) |=> !br_taken);

    a_r5_taken_only_relative: assert property (@(posedge clk) disable iff (rst)
        (load && mode != AM_RELATIVE) |=> !br_taken && (br_target == '0));

    a_r6_no_mem: assert property (@(posedge clk) disable iff (rst)
        (load && (mode == AM_INHERENT || mode == AM_IMMEDIATE || mode == AM_RELATIVE
                  || mode > AM_RELATIVE)) |=> !mem_req && (ea == '0));

    a_r7_next_byte: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (ea_plus1 == ea + 16'd1));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ea) && $stable(ea_plus1) && $stable(mem_req)
                  && $stable(br_target) && $stable(br_taken));
endmodule

bind eag_core eag_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .mode      (mode),
    .op_hi     (op_hi),
    .op_lo     (op_lo),
    .zero_flag (zero_flag),
    .ea        (ea),
    .ea_plus1  (ea_plus1),
    .mem_req   (mem_req),
    .br_target (br_target),
    .br_taken  (br_taken)
);

// File: tb/eag_core_test.sv
module eag_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    typedef struct packed {
        logic [2:0]  mode;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [15:0] x;
        logic [15:0] pc;
        logic        z;
        logic [15:0] e_ea;
        logic [15:0] e_p1;
        logic        e_mem;
        logic [15:0] e_tgt;
        logic        e_tk;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{3'd3, 8'hC2, 8'h00, 16'h1234, 16'h4000, 1'b0, 16'hC200, 16'hC201, 1'b1, 16'h0000, 1'b0},
        '{3'd3, 8'hFF, 8'hFF, 16'h1234, 16'h4000, 1'b0, 16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b0},
        '{3'd2, 8'hAB, 8'h7F, 16'h1234, 16'h4000, 1'b0, 16'h007F, 16'h0080, 1'b1, 16'h0000, 1'b0},
        '{3'd2, 8'h00, 8'hFF, 16'h1234, 16'h4000, 1'b0, 16'h00FF, 16'h0100, 1'b1, 16'h0000, 1'b0},
        '{3'd4, 8'h33, 8'h02, 16'h1000, 16'h4000, 1'b0, 16'h1002, 16'h1003, 1'b1, 16'h0000, 1'b0},
        '{3'd4, 8'h33, 8'hFF, 16'h1000, 16'h4000, 1'b0, 16'h10FF, 16'h1100, 1'b1, 16'h0000, 1'b0},
        '{3'd4, 8'h33, 8'h80, 16'hFFF0, 16'h4000, 1'b0, 16'h0070, 16'h0071, 1'b1, 16'h0000, 1'b0},
        '{3'd1, 8'h55, 8'h66, 16'h1234, 16'h4000, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
        '{3'd0, 8'h55, 8'h66, 16'h1234, 16'h4000, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
        '{3'd5, 8'h00, 8'h10, 16'h1234, 16'h2000, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h2010, 1'b1},
        '{3'd5, 8'h00, 8'hF0, 16'h1234, 16'h2000, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h1FF0, 1'b1},
        '{3'd5, 8'h00, 8'hFE, 16'h1234, 16'h2000, 1'b1, 16'h0000, 16'h0000, 1'b0, 16'h1FFE, 1'b0},
        '{3'd5, 8'h00, 8'h80, 16'h1234, 16'h0010, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'hFF90, 1'b1},
        '{3'd5, 8'h00, 8'h7F, 16'h1234, 16'hFFF0, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h006F, 1'b1},
        '{3'd6, 8'h12, 8'h34, 16'h5678, 16'h9ABC, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
        '{3'd7, 8'h12, 8'h34, 16'h5678, 16'h9ABC, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
        '{3'd3, 8'h01, 8'h10, 16'h1234, 16'h4000, 1'b1, 16'h0110, 16'h0111, 1'b1, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [2:0]  mode = '0;
    logic [7:0]  op_hi = '0;
    logic [7:0]  op_lo = '0;
    logic [15:0] index_x = '0;
    logic [15:0] pc_next = '0;
    logic        zero_flag = 1'b0;
    logic [15:0] ea, ea_plus1, br_target;
    logic        mem_req, br_taken;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eag_core uut (
        .clk(clk), .rst(rst), .load(load), .mode(mode),
        .op_hi(op_hi), .op_lo(op_lo), .index_x(index_x), .pc_next(pc_next),
        .zero_flag(zero_flag), .ea(ea), .ea_plus1(ea_plus1), .mem_req(mem_req),
        .br_target(br_target), .br_taken(br_taken)
    );

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd3:    return "R1/R7";
            3'd2:    return "R2/R7";
            3'd4:    return "R3/R7";
            3'd5:    return "R4/R5/R6";
            default: return "R6/R5";
        endcase
    endfunction

    task automatic compare(input string req, input logic [15:0] e_ea, input logic [15:0] e_p1,
                           input logic e_mem, input logic [15:0] e_tgt, input logic e_tk);
        checks++;
        if (ea !== e_ea || ea_plus1 !== e_p1 || mem_req !== e_mem ||
            br_target !== e_tgt || br_taken !== e_tk) begin
            fails++;
            $display("FAIL %s: got ea=%h p1=%h mem=%b tgt=%h tk=%b, expected ea=%h p1=%h mem=%b tgt=%h tk=%b",
                     req, ea, ea_plus1, mem_req, br_target, br_taken,
                     e_ea, e_p1, e_mem, e_tgt, e_tk);
        end
    endtask

    task automatic drive(input vec_t v);
        mode = v.mode; op_hi = v.hi; op_lo = v.lo;
        index_x = v.x; pc_next = v.pc; zero_flag = v.z;
    endtask

    task automatic capture(input vec_t v);
        @(negedge clk);
        drive(v);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        compare("R9", 16'h0, 16'h0, 1'b0, 16'h0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            capture(VEC[i]);
            compare(tag_of(VEC[i].mode), VEC[i].e_ea, VEC[i].e_p1, VEC[i].e_mem,
                    VEC[i].e_tgt, VEC[i].e_tk);
        end

        // R8: load low, inputs change, outputs hold the last indexed capture
        capture(VEC[5]);
        @(negedge clk);
        drive(VEC[9]);
        @(negedge clk);
        @(negedge clk);
        compare("R8", 16'h10FF, 16'h1100, 1'b1, 16'h0000, 1'b0);

        // R8: a branch capture, then memory-mode inputs without load
        capture(VEC[10]);
        drive(VEC[0]);
        @(negedge clk);
        compare("R8", 16'h0000, 16'h0000, 1'b0, 16'h1FF0, 1'b1);

        // R2: page zero ignores the upper operand byte
        capture('{3'd2, 8'hFF, 8'h00, 16'hFFFF, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b0});
        compare("R2", 16'h0000, 16'h0001, 1'b1, 16'h0000, 1'b0);

        // R9: reset mid-run clears a held result
        capture(VEC[0]);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        compare("R9", 16'h0, 16'h0, 1'b0, 16'h0, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule